// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Recency Replacement

This block caches virtual-to-physical page mappings for a processor's memory pipeline. A lookup presents a virtual address and, in the same cycle, gets a hit flag, the physical address and the mapping's attribute bits. When no slot matches, a miss indication goes out together with the offending virtual address, so that an external fill agent can fetch the mapping. The agent then hands it back through the insert stream.

Every slot stores its own page size. A slot matches any address from its virtual base up to, but not including, its base plus its size. Replacement follows a recency list. Empty slots are always filled first. After that, the least recently used slot is overwritten. The lookup side can promote the slot it hits to the front of the list, or it can peek without disturbing the order. Promotion is optional, so a speculative or debug probe does not distort replacement.

The insert stream is valid/ready. The fill agent holds its valid and its payload steady until it sees ready at a rising edge. Ready drops only in a cycle in which a promoting lookup hits, because both operations would reorder the list. An insert that is refused is simply presented again in the next cycle. The lookup side has no back-pressure and is never stalled.

Top module: `tlb_fa_lru`

## Requirements
- R1: After a synchronous reset every slot is free. Any lookup misses, and ins_ready is high when no lookup is presented.
- R2: A slot matches when vbase <= address < vbase + size. On a hit, lk_paddr equals the slot's physical base OR-ed with address bits [11:0], and lk_attr carries the slot's attributes. The attribute bit order is [5] writeable, [4] user, [3] uncacheable, [2] global, [1] PAT index, [0] no-execute.
- R3: A valid lookup that matches no slot drives lk_hit low and miss_valid high, and miss_vaddr equals the lookup address. When lk_valid is low, neither lk_hit nor miss_valid is asserted.
- R4: While any slot is free, an accepted insert takes a free slot and evicts nothing. ENTRIES distinct inserts after reset all remain resident.
- R5: When every slot is occupied, an accepted insert overwrites the least recently used slot.
- R6: A newly inserted mapping becomes the most recently used one.
- R7: A hitting lookup with lk_update high moves the hit slot to the most recently used position at the next rising edge.
- R8: A lookup with lk_update low leaves the recency order unchanged.
- R9: When several slots match, the most recently used matching slot supplies the translation.
- R10: ins_ready is low exactly in the cycles in which lk_valid, lk_update and a hit coincide. An insert is accepted only on a rising edge that sees both ins_valid and ins_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | VA_W | Lookup virtual address |
| lk_update | input | 1 | Promote the hit slot to most recently used |
| lk_hit | output | 1 | Lookup matched a slot (combinational) |
| lk_paddr | output | PA_W | Translated physical address, zero without a hit |
| lk_attr | output | 6 | Attribute bits of the hit slot, zero without a hit |
| miss_valid | output | 1 | Lookup found no mapping |
| miss_vaddr | output | VA_W | Virtual address that missed |
| ins_valid | input | 1 | Insert payload present |
| ins_ready | output | 1 | Insert can be accepted this cycle |
| ins_vbase | input | VA_W | Page-aligned virtual base of the new mapping |
| ins_size | input | VA_W | Page size in bytes |
| ins_pbase | input | PA_W | Physical page base |
| ins_attr | input | 6 | Attribute bits, in the order given in R2 |

## Verification
The translation path is tested with directed lookups on a large page, at its first byte, its last byte and one byte either side, so that an off-by-one in either range bound appears as a wrong hit or a missed hit. Replacement is tested with a full fill followed by overflow inserts, run once with peek-only lookups and once with a promoting lookup in between. The eviction victim differs between the two runs, so a lost promotion and a spurious promotion each show up. Duplicate inserts of the same page, and a promoting hit that collides with an insert, cover the priority of the most recent match and the back-pressure rule. A long seeded random mix of inserts over a page pool larger than the buffer is compared against an ordered-list model, which exercises eviction, promotion and conflicting mappings in interleavings that the directed cases do not reach.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  localparam int OFFS_W = 12;

  typedef struct packed {
    logic wr;
    logic usr;
    logic nocache;
    logic glob;
    logic pat;
    logic nx;
  } tlb_attr_t;

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N    = 64,
  parameter int VA_W = 32
) (
  input  logic [N-1:0]           valid,
  input  logic [N-1:0][VA_W-1:0] vbase,
  input  logic [N-1:0][VA_W-1:0] size,
  input  logic [VA_W-1:0]        va,
  output logic [N-1:0]           match
);

  // Range compare per slot; the top bound is widened by one bit so that
  // a page ending at the top of the address space does not wrap.
  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic [VA_W:0] limit;
    assign limit    = {1'b0, vbase[g]} + {1'b0, size[g]};
    assign match[g] = valid[g] && (va >= vbase[g]) && ({1'b0, va} < limit);
  end

endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int N    = 64,
  parameter int VA_W = 32,
  parameter int PA_W = 32,
  localparam int IW  = $clog2(N)
) (
  input  logic                   clk,
  input  logic                   we,
  input  logic [IW-1:0]          widx,
  input  logic [VA_W-1:0]        w_vbase,
  input  logic [VA_W-1:0]        w_size,
  input  logic [PA_W-1:0]        w_pbase,
  input  tlb_attr_t              w_attr,
  input  logic [IW-1:0]          rd_idx,
  output logic [N-1:0][VA_W-1:0] vbase_all,
  output logic [N-1:0][VA_W-1:0] size_all,
  output logic [PA_W-1:0]        rd_pbase,
  output tlb_attr_t              rd_attr
);

  logic [N-1:0][PA_W-1:0] pbase_q;
  tlb_attr_t [N-1:0]      attr_q;
  logic [N-1:0][VA_W-1:0] vbase_q;
  logic [N-1:0][VA_W-1:0] size_q;

  // Payload needs no reset: the recency unit's valid bits gate every match.
  always_ff @(posedge clk) begin
    if (we) begin
      vbase_q[widx] <= w_vbase;
      size_q[widx]  <= w_size;
      pbase_q[widx] <= w_pbase;
      attr_q[widx]  <= w_attr;
    end
  end

  assign vbase_all = vbase_q;
  assign size_all  = size_q;
  assign rd_pbase  = pbase_q[rd_idx];
  assign rd_attr   = attr_q[rd_idx];

endmodule

// File: rtl/tlb_recency.sv
module tlb_recency #(
  parameter int N   = 64,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  match,
  input  logic          promote,
  input  logic          ins_fire,
  output logic [N-1:0]  valid,
  output logic          hit,
  output logic [IW-1:0] hit_idx,
  output logic [IW-1:0] vic_idx
);

  localparam logic [IW-1:0] LAST = IW'(N - 1);

  // rank 0 = most recently used; free slots always hold rank LAST,
  // occupied slots hold the distinct ranks 0 .. count-1.
  logic [N-1:0][IW-1:0] rank_q;
  logic [N-1:0]         valid_q;

  logic [IW-1:0] best_rank;

  // Most recently used match wins (R9).
  always_comb begin
    hit       = 1'b0;
    best_rank = LAST;
    hit_idx   = '0;
    for (int i = 0; i < N; i++) begin
      if (match[i] && (!hit || rank_q[i] < best_rank)) begin
        hit       = 1'b1;
        best_rank = rank_q[i];
        hit_idx   = IW'(i);
      end
    end
  end

  // Lowest free slot first, otherwise the slot ranked last (R4, R5).
  always_comb begin
    vic_idx = '0;
    if (!(&valid_q)) begin
      for (int i = N - 1; i >= 0; i--)
        if (!valid_q[i]) vic_idx = IW'(i);
    end else begin
      for (int i = 0; i < N; i++)
        if (rank_q[i] == LAST) vic_idx = IW'(i);
    end
  end

  logic [IW-1:0] pivot;
  logic [IW-1:0] target;
  logic          move;

  assign move   = ins_fire || promote;
  assign target = ins_fire ? vic_idx : hit_idx;
  assign pivot  = rank_q[target];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
      for (int i = 0; i < N; i++) rank_q[i] <= LAST;
    end else if (move) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == target) begin
          rank_q[i] <= '0;
          if (ins_fire) valid_q[i] <= 1'b1;
        end else if (valid_q[i] && rank_q[i] < pivot) begin
          rank_q[i] <= rank_q[i] + 1'b1;
        end
      end
    end
  end

  assign valid = valid_q;

  // Registered copies used only by the properties below.
  logic [IW-1:0] ins_idx_q;
  logic [IW-1:0] hit_idx_q;
  always_ff @(posedge clk) begin
    ins_idx_q <= vic_idx;
    hit_idx_q <= hit_idx;
  end

  // R4: a free slot is taken before anything is evicted.
  a_r4_free_first: assert property (@(posedge clk) disable iff (rst)
    (ins_fire && !(&valid_q)) |-> !valid_q[vic_idx]);

  // R6: the inserted slot is resident and most recent afterwards.
  a_r6_insert_mru: assert property (@(posedge clk) disable iff (rst)
    ins_fire |=> (valid_q[ins_idx_q] && rank_q[ins_idx_q] == '0));

  // R7: a promoted slot sits at the front afterwards.
  a_r7_promote: assert property (@(posedge clk) disable iff (rst)
    (promote && !ins_fire) |=> (rank_q[hit_idx_q] == '0));

  // R8: a peek leaves the order alone.
  a_r8_peek_hold: assert property (@(posedge clk) disable iff (rst)
    (!promote && !ins_fire) |=> ($stable(rank_q) && $stable(valid_q)));

endmodule

// File: rtl/tlb_fa_lru.sv
module tlb_fa_lru
  import tlb_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lk_valid,
  input  logic [VA_W-1:0] lk_vaddr,
  input  logic            lk_update,
  output logic            lk_hit,
  output logic [PA_W-1:0] lk_paddr,
  output logic [5:0]      lk_attr,
  output logic            miss_valid,
  output logic [VA_W-1:0] miss_vaddr,
  input  logic            ins_valid,
  output logic            ins_ready,
  input  logic [VA_W-1:0] ins_vbase,
  input  logic [VA_W-1:0] ins_size,
  input  logic [PA_W-1:0] ins_pbase,
  input  logic [5:0]      ins_attr
);

  localparam int IW = $clog2(ENTRIES);

  logic [ENTRIES-1:0]           valid;
  logic [ENTRIES-1:0]           match;
  logic [ENTRIES-1:0][VA_W-1:0] vbase_all;
  logic [ENTRIES-1:0][VA_W-1:0] size_all;
  logic                         hit;
  logic [IW-1:0]                hit_idx;
  logic [IW-1:0]                vic_idx;
  logic [PA_W-1:0]              rd_pbase;
  tlb_attr_t                    rd_attr;
  logic                         promote;
  logic                         ins_fire;

  tlb_match #(.N(ENTRIES), .VA_W(VA_W)) u_match (
    .valid (valid),
    .vbase (vbase_all),
    .size  (size_all),
    .va    (lk_vaddr),
    .match (match)
  );

  // A promoting hit owns the recency list this cycle; inserts wait.
  assign promote   = lk_valid && lk_update && hit;
  assign ins_ready = !promote;
  assign ins_fire  = ins_valid && ins_ready;

  tlb_recency #(.N(ENTRIES)) u_rec (
    .clk      (clk),
    .rst      (rst),
    .match    (match),
    .promote  (promote),
    .ins_fire (ins_fire),
    .valid    (valid),
    .hit      (hit),
    .hit_idx  (hit_idx),
    .vic_idx  (vic_idx)
  );

  tlb_store #(.N(ENTRIES), .VA_W(VA_W), .PA_W(PA_W)) u_store (
    .clk       (clk),
    .we        (ins_fire),
    .widx      (vic_idx),
    .w_vbase   (ins_vbase),
    .w_size    (ins_size),
    .w_pbase   (ins_pbase),
    .w_attr    (tlb_attr_t'(ins_attr)),
    .rd_idx    (hit_idx),
    .vbase_all (vbase_all),
    .size_all  (size_all),
    .rd_pbase  (rd_pbase),
    .rd_attr   (rd_attr)
  );

  assign lk_hit     = lk_valid && hit;
  assign lk_paddr   = lk_hit ? (rd_pbase | PA_W'(lk_vaddr[OFFS_W-1:0])) : '0;
  assign lk_attr    = lk_hit ? 6'(rd_attr) : '0;
  assign miss_valid = lk_valid && !hit;
  assign miss_vaddr = lk_vaddr;

endmodule

// File: tb/tlb_fa_lru_tb.sv
module tlb_fa_lru_tb;

  localparam int N = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0, lk_update = 1'b0, ins_valid = 1'b0;
  logic [31:0] lk_vaddr = '0, ins_vbase = '0, ins_size = '0, ins_pbase = '0;
  logic [5:0]  ins_attr = '0;
  logic        lk_hit, miss_valid, ins_ready;
  logic [31:0] lk_paddr, miss_vaddr;
  logic [5:0]  lk_attr;

  always #5 clk = ~clk;

  tlb_fa_lru u_dut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_vaddr(lk_vaddr),
    .lk_update(lk_update), .lk_hit(lk_hit), .lk_paddr(lk_paddr),
    .lk_attr(lk_attr), .miss_valid(miss_valid), .miss_vaddr(miss_vaddr),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_vbase(ins_vbase),
    .ins_size(ins_size), .ins_pbase(ins_pbase), .ins_attr(ins_attr)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;

  // Reference: ordered list, index 0 = most recently used.
  logic [31:0] mv[N], ms[N], mp[N];
  logic [5:0]  ma[N];
  int          mcnt = 0;

  task automatic chk(string tag, logic ok, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int m_find(logic [31:0] va);
    for (int i = 0; i < mcnt; i++)
      if (va >= mv[i] && {1'b0, va} < ({1'b0, mv[i]} + {1'b0, ms[i]})) return i;
    return -1;
  endfunction

  task automatic m_promote(int k);
    logic [31:0] v = mv[k], s = ms[k], p = mp[k];
    logic [5:0] a = ma[k];
    for (int j = k; j > 0; j--) begin
      mv[j] = mv[j-1]; ms[j] = ms[j-1]; mp[j] = mp[j-1]; ma[j] = ma[j-1];
    end
    mv[0] = v; ms[0] = s; mp[0] = p; ma[0] = a;
  endtask

  task automatic m_insert(logic [31:0] v, logic [31:0] s, logic [31:0] p, logic [5:0] a);
    if (mcnt < N) mcnt++;
    for (int j = mcnt - 1; j > 0; j--) begin
      mv[j] = mv[j-1]; ms[j] = ms[j-1]; mp[j] = mp[j-1]; ma[j] = ma[j-1];
    end
    mv[0] = v; ms[0] = s; mp[0] = p; ma[0] = a;
  endtask

  task automatic step(string tag, logic lv, logic [31:0] va, logic upd,
                      logic iv, logic [31:0] ivb, logic [31:0] isz,
                      logic [31:0] ip, logic [5:0] ia);
    int k;
    logic eh, erdy;
    @(negedge clk);
    lk_valid = lv; lk_vaddr = va; lk_update = upd;
    ins_valid = iv; ins_vbase = ivb; ins_size = isz; ins_pbase = ip; ins_attr = ia;
    #1;
    k = m_find(va);
    eh = lv && (k >= 0);
    erdy = !(lv && upd && k >= 0);
    chk({tag, " hit"}, lk_hit === eh, lk_hit, eh);
    chk({tag, " miss"}, miss_valid === (lv && k < 0), miss_valid, lv && k < 0);
    if (lv && k < 0) chk({tag, " miss_vaddr"}, miss_vaddr === va, miss_vaddr, va);
    if (eh) begin
      chk({tag, " paddr"}, lk_paddr === (mp[k] | {20'd0, va[11:0]}), lk_paddr,
          mp[k] | {20'd0, va[11:0]});
      chk({tag, " attr"}, lk_attr === ma[k], lk_attr, ma[k]);
    end
    chk({tag, " R10 ready"}, ins_ready === erdy, ins_ready, erdy);
    if (!erdy) m_promote(k);
    else if (iv) m_insert(ivb, isz, ip, ia);
  endtask

  task automatic look(string tag, logic [31:0] va, logic upd);
    step(tag, 1'b1, va, upd, 1'b0, '0, '0, '0, '0);
  endtask

  task automatic put(string tag, logic [31:0] v, logic [31:0] s, logic [31:0] p, logic [5:0] a);
    step(tag, 1'b0, '0, 1'b0, 1'b1, v, s, p, a);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; lk_valid = 0; ins_valid = 0; lk_update = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mcnt = 0;
  endtask

  function automatic logic [31:0] pg(int k);
    return 32'h1000_0000 + 32'(k) * 32'h1000;
  endfunction

  initial begin
    void'($urandom(32'd7));
    do_reset();
    // R1 / R3: empty after reset
    #1;
    chk("R1 ready idle", ins_ready === 1'b1, ins_ready, 1);
    chk("R3 idle no miss", miss_valid === 1'b0 && lk_hit === 1'b0, miss_valid, 0);
    look("R1 empty", 32'h1000_0123, 1'b1);
    look("R3 miss", 32'hDEAD_BEEF, 1'b0);

    // R2: large page bounds
    put("R2 ins", 32'h4000_0000, 32'h0020_0000, 32'h8000_0000, 6'b101010);
    look("R2 first", 32'h4000_0000, 1'b0);
    look("R2 last", 32'h401F_FFFF, 1'b0);
    look("R2 above", 32'h4020_0000, 1'b0);
    look("R2 below", 32'h3FFF_FFFF, 1'b0);

    // R9: duplicate mapping, newest wins
    put("R9 ins a", 32'h5000_0000, 32'h1000, 32'h1111_1000, 6'b000001);
    put("R9 ins b", 32'h5000_0000, 32'h1000, 32'h2222_2000, 6'b110000);
    look("R9 newest", 32'h5000_0ABC, 1'b0);

    // R10: promoting hit blocks the insert
    step("R10 collide", 1'b1, 32'h4000_0010, 1'b1, 1'b1, 32'h6000_0000, 32'h1000, 32'h7000_0000, 6'h3F);
    look("R10 refused", 32'h6000_0000, 1'b0);
    step("R10 retry", 1'b1, 32'h4000_0010, 1'b0, 1'b1, 32'h6000_0000, 32'h1000, 32'h7000_0000, 6'h3F);
    look("R10 taken", 32'h6000_0004, 1'b0);

    // R4 / R5 / R6 / R8: fill, peek, overflow
    do_reset();
    for (int k = 0; k < N; k++) put("R4 fill", pg(k), 32'h1000, 32'hA000_0000 + 32'(k) * 32'h1000, 6'(k));
    for (int k = 0; k < N; k++) look("R4 R8 resident", pg(k) + 32'h10, 1'b0);
    put("R5 overflow", pg(N), 32'h1000, 32'hB000_0000, 6'h15);
    look("R5 lru gone", pg(0), 1'b0);
    look("R6 new mru", pg(N) + 32'h7, 1'b0);
    // R7: promotion saves the slot next in line
    look("R7 promote", pg(1), 1'b1);
    put("R7 overflow", pg(N + 1), 32'h1000, 32'hB000_1000, 6'h2A);
    look("R7 kept", pg(1), 1'b0);
    look("R7 next evicted", pg(2), 1'b0);
    put("R8 overflow", pg(N + 2), 32'h1000, 32'hB000_2000, 6'h0F);
    look("R8 evicted", pg(3), 1'b0);

    // Random mix against the model (R2..R10)
    do_reset();
    for (int c = 0; c < 4000; c++) begin
      logic lv, upd, iv;
      logic [31:0] va, ivb, isz;
      lv  = ($urandom % 10) < 8;
      upd = $urandom % 2;
      iv  = ($urandom % 10) < 4;
      if ($urandom % 8 == 0) va = 32'h2000_0000 + ($urandom % 4) * 32'h20_0000 + ($urandom % 32'h20_0000);
      else va = pg($urandom % 96) + ($urandom % 32'h1000);
      if ($urandom % 10 == 0) begin
        ivb = 32'h2000_0000 + ($urandom % 4) * 32'h20_0000; isz = 32'h20_0000;
      end else begin
        ivb = pg($urandom % 96); isz = 32'h1000;
      end
      step("R5 R7 R9 random", lv, va, upd, iv, ivb, isz,
           {$urandom % 32'h10_0000, 12'h000}, 6'($urandom));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule